// File: doc/BRIEF.md
# Interrupt Priority Arbiter

This block selects one winning interrupt line out of one to three banks of 32 lines. For each line it receives a pending bit, a mask bit, a class-steering bit and a priority field. A line takes part only when it is pending, unmasked and steered to the class that the instance serves. The instance serves either the normal class or the fast class, chosen by a parameter.

Among the lines that take part, the line with the smallest priority value wins. When several lines share that value, the line with the largest global number wins. The block reports the winner's global number. It also reports a flag that is set whenever any line takes part, so a winner of line 0 can be told apart from an idle state.

The search is a balanced tree of compare-select nodes. An optional output register can be placed after the tree. A surrounding controller latches the vector, drives the processor request and decodes the registers. Instances for the two classes sit side by side on the same state.

Top module: `irq_prio_arbiter`

## Requirements
- R1: A line is eligible only when its pending bit is 1, its mask bit is 0 and its steering bit equals FIQ_CLASS. With FIQ_CLASS=0 the steering bit must be 0; with FIQ_CLASS=1 it must be 1.
- R2: Among eligible lines, the winner is the one whose priority field (PRIO_W bits, unsigned) has the smallest value.
- R3: When eligible lines share the smallest priority value, the line with the highest global number wins.
- R4: Line `b*32+k` is bit `b*32+k` of `pend_i`, `mask_i` and `fiq_sel_i`, and its priority is `prio_i[(b*32+k)*PRIO_W +: PRIO_W]`. A winning line reports `winner_o = b*32+k`.
- R5: When no line is eligible, `winner_o` is 0 and `any_o` is 0.
- R6: `any_o` is 1 exactly when at least one line is eligible. This includes the case where line 0 alone is eligible and `winner_o` is 0.
- R7: With OUT_REG=1, the outputs reflect the inputs sampled at the previous rising clock edge, and both outputs read 0 while `rst_ni` is low. With OUT_REG=0, the outputs follow the inputs with no clock delay.
- R8: A masked line, or a line steered to the other class, has no effect on the result, even when its priority value is lower than that of every eligible line.
- R9: A line whose priority is the all-ones value still wins when it is the only eligible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_BANKS*32 | Pending bit per line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line, 1 = blocked |
| fiq_sel_i | input | NUM_BANKS*32 | Class steering per line, 1 = fast class |
| prio_i | input | NUM_BANKS*32*PRIO_W | Priority field per line, smaller is more urgent |
| winner_o | output | $clog2(NUM_BANKS*32) | Global number of the winning line |
| any_o | output | 1 | At least one eligible line exists |

## Verification
Tie resolution toward the higher line and exclusion of masked or wrong-class lines can act in the same cycle. The bench provokes this by giving many lines the same priority while a more urgent line elsewhere is masked or steered away. It then judges that the winner is still the highest-numbered line among the eligible tied group. Random patterns mix all four per-line inputs on both a registered normal-class instance and a combinational fast-class instance. Both instances are compared each time against an ascending scan, in which a later line of equal or lower priority replaces the current best.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int unsigned LINES_PER_BANK = 32;
  localparam int unsigned MAX_BANKS      = 3;
endpackage

// File: rtl/arb_elig.sv
module arb_elig #(
  parameter int unsigned NUM_LINES = 32,
  parameter bit          FIQ_CLASS = 1'b0
) (
  input  logic [NUM_LINES-1:0] pend_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] fiq_sel_i,
  output logic [NUM_LINES-1:0] elig_o
);
  logic [NUM_LINES-1:0] class_ok;

  generate
    if (FIQ_CLASS) begin : g_fast
      assign class_ok = fiq_sel_i;
    end else begin : g_norm
      assign class_ok = ~fiq_sel_i;
    end
  endgenerate

  assign elig_o = pend_i & ~mask_i & class_ok;
endmodule

// File: rtl/arb_cmp_node.sv
module arb_cmp_node #(
  parameter int unsigned PRIO_W = 6,
  parameter int unsigned IDX_W  = 7
) (
  input  logic              l_v_i,
  input  logic [PRIO_W-1:0] l_p_i,
  input  logic [IDX_W-1:0]  l_x_i,
  input  logic              r_v_i,
  input  logic [PRIO_W-1:0] r_p_i,
  input  logic [IDX_W-1:0]  r_x_i,
  output logic              o_v_o,
  output logic [PRIO_W-1:0] o_p_o,
  output logic [IDX_W-1:0]  o_x_o
);
  logic take_r;

  // right operand holds the higher indices: it wins on equal priority
  assign take_r = r_v_i & (~l_v_i | (r_p_i <= l_p_i));
  assign o_v_o  = l_v_i | r_v_i;

  always_comb begin
    if (take_r) begin
      o_p_o = r_p_i;
      o_x_o = r_x_i;
    end else if (l_v_i) begin
      o_p_o = l_p_i;
      o_x_o = l_x_i;
    end else begin
      o_p_o = '0;
      o_x_o = '0;
    end
  end
endmodule

// File: rtl/arb_tree.sv
module arb_tree #(
  parameter int unsigned NUM_LINES = 96,
  parameter int unsigned PRIO_W    = 6,
  parameter int unsigned IDX_W     = 7
) (
  input  logic [NUM_LINES-1:0]        elig_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic                        root_v_o,
  output logic [PRIO_W-1:0]           root_p_o,
  output logic [IDX_W-1:0]            root_x_o
);
  localparam int unsigned LEAVES = 1 << IDX_W;
  localparam int unsigned NODES  = 2 * LEAVES - 1;

  logic              nv [NODES];
  logic [PRIO_W-1:0] np [NODES];
  logic [IDX_W-1:0]  nx [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < NUM_LINES) begin : g_real
      assign nv[LEAVES-1+i] = elig_i[i];
      assign np[LEAVES-1+i] = prio_i[i*PRIO_W +: PRIO_W];
    end else begin : g_pad
      assign nv[LEAVES-1+i] = 1'b0;
      assign np[LEAVES-1+i] = '0;
    end
    assign nx[LEAVES-1+i] = IDX_W'(i);
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    arb_cmp_node #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_node (
      .l_v_i (nv[2*k+1]),
      .l_p_i (np[2*k+1]),
      .l_x_i (nx[2*k+1]),
      .r_v_i (nv[2*k+2]),
      .r_p_i (np[2*k+2]),
      .r_x_i (nx[2*k+2]),
      .o_v_o (nv[k]),
      .o_p_o (np[k]),
      .o_x_o (nx[k])
    );
  end

  assign root_v_o = nv[0];
  assign root_p_o = np[0];
  assign root_x_o = nx[0];
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import arb_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned PRIO_W    = 6,
  parameter bit          FIQ_CLASS = 1'b0,
  parameter bit          OUT_REG   = 1'b1,
  localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK,
  localparam int unsigned IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_LINES-1:0]        pend_i,
  input  logic [NUM_LINES-1:0]        mask_i,
  input  logic [NUM_LINES-1:0]        fiq_sel_i,
  input  logic [NUM_LINES*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]            winner_o,
  output logic                        any_o
);
  logic [NUM_LINES-1:0] elig;
  logic                 root_v;
  logic [PRIO_W-1:0]    root_p;
  logic [IDX_W-1:0]     root_x;

  arb_elig #(.NUM_LINES(NUM_LINES), .FIQ_CLASS(FIQ_CLASS)) u_elig (
    .pend_i    (pend_i),
    .mask_i    (mask_i),
    .fiq_sel_i (fiq_sel_i),
    .elig_o    (elig)
  );

  arb_tree #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_tree (
    .elig_i   (elig),
    .prio_i   (prio_i),
    .root_v_o (root_v),
    .root_p_o (root_p),
    .root_x_o (root_x)
  );

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          winner_o <= '0;
          any_o    <= 1'b0;
        end else begin
          winner_o <= root_x;
          any_o    <= root_v;
        end
      end
    end else begin : g_comb
      assign winner_o = root_x;
      assign any_o    = root_v;
    end
  endgenerate

  // checker state: a more urgent or equal-and-higher eligible line exists
  logic beaten;
  always_comb begin
    beaten = 1'b0;
    for (int j = 0; j < NUM_LINES; j++) begin
      if (root_v && elig[j]) begin
        if (prio_i[j*PRIO_W +: PRIO_W] < root_p) beaten = 1'b1;
        if (prio_i[j*PRIO_W +: PRIO_W] == root_p && IDX_W'(j) > root_x) beaten = 1'b1;
      end
    end
  end

  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_winner_eligible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_v |-> elig[root_x]);

  a_r2_r3_no_better_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !beaten);

  a_r6_any_tracks_elig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    root_v == (|elig));

  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !root_v |-> (root_x == '0));

  a_r7_out_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OUT_REG && past_ok) |=> (winner_o == $past(root_x)) && (any_o == $past(root_v)));
endmodule

// File: tb/irq_prio_arbiter_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arbiter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [95:0]  pend, mask, fiq;
  logic [575:0] prio6;
  logic [159:0] prio5;
  logic [6:0]   w3;
  logic         a3;
  logic [4:0]   w1;
  logic         a1;

  always_comb
    for (int i = 0; i < 32; i++) prio5[i*5 +: 5] = prio6[i*6 +: 5];

  irq_prio_arbiter #(.NUM_BANKS(3), .PRIO_W(6), .FIQ_CLASS(1'b0), .OUT_REG(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .mask_i(mask), .fiq_sel_i(fiq),
    .prio_i(prio6), .winner_o(w3), .any_o(a3));

  irq_prio_arbiter #(.NUM_BANKS(1), .PRIO_W(5), .FIQ_CLASS(1'b1), .OUT_REG(1'b0)) dut_c_i (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend[31:0]), .mask_i(mask[31:0]),
    .fiq_sel_i(fiq[31:0]), .prio_i(prio5), .winner_o(w1), .any_o(a1));

  int checks = 0;
  int failures = 0;
  int prev_w = 0;
  bit prev_a = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void ref_scan(int nb, int pw, bit cls, output int win, output bit any);
    int best;
    best = 255;
    win = 0;
    any = 0;
    for (int l = 0; l < nb * 32; l++) begin
      if (pend[l] && !mask[l] && fiq[l] == cls) begin
        int p;
        p = int'(prio6[l*6 +: 6]) & ((1 << pw) - 1);
        if (p <= best) begin
          best = p;
          win = l;
          any = 1;
        end
      end
    end
  endfunction

  // inputs were changed at a falling edge just before the call
  task automatic run(string tag);
    int ew3, ew1;
    bit ea3, ea1;
    ref_scan(3, 6, 1'b0, ew3, ea3);
    ref_scan(1, 5, 1'b1, ew1, ea1);
    #1;
    chk({tag, " R7 reg lag winner"}, int'(w3), prev_w);
    chk({tag, " R7 reg lag any"}, int'(a3), int'(prev_a));
    chk({tag, " fast comb winner"}, int'(w1), ew1);
    chk({tag, " fast comb any"}, int'(a1), int'(ea1));
    @(negedge clk);
    chk({tag, " norm winner"}, int'(w3), ew3);
    chk({tag, " norm any"}, int'(a3), int'(ea3));
    prev_w = ew3;
    prev_a = ea3;
  endtask

  task automatic clear_all();
    pend = '0; mask = '0; fiq = '0; prio6 = '0;
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_all();
    repeat (3) @(negedge clk);
    chk("R7 reset winner", int'(w3), 0);
    chk("R7 reset any", int'(a3), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R1: each line alone, steering alternates by line parity
    for (int l = 0; l < 96; l++) begin
      clear_all();
      pend[l] = 1'b1;
      fiq[l] = l[0];
      prio6[l*6 +: 6] = 6'($urandom);
      run("R4 R1 single line");
    end

    // R3: all lines tied, normal class
    clear_all();
    pend = '1;
    for (int l = 0; l < 96; l++) prio6[l*6 +: 6] = 6'd7;
    run("R3 tie all normal");
    chk("R3 tie picks top line", prev_w, 95);
    // R3: all tied, fast class
    fiq = '1;
    run("R3 tie all fast");

    // R8 with R3: urgent masked and wrong-class lines, tied group below
    clear_all();
    pend = '1;
    for (int l = 0; l < 96; l++) prio6[l*6 +: 6] = 6'd9;
    mask[10] = 1'b1; prio6[10*6 +: 6] = 6'd0;
    fiq[77] = 1'b1;  prio6[77*6 +: 6] = 6'd1;
    prio6[20*6 +: 6] = 6'd3; prio6[40*6 +: 6] = 6'd3; mask[40] = 1'b1;
    prio6[5*6 +: 6] = 6'd3;
    run("R8 excluded urgent lines");
    chk("R8 winner is 20", prev_w, 20);

    // R5: nothing eligible
    clear_all();
    pend = '1; mask = '1;
    run("R5 all masked");
    clear_all();
    run("R5 none pending");

    // R6: line 0 alone
    clear_all();
    pend[0] = 1'b1; prio6[5:0] = 6'd12;
    run("R6 line zero");
    clear_all();
    pend[0] = 1'b1; fiq[0] = 1'b1;
    run("R6 line zero fast");

    // R9: all-ones priority alone
    clear_all();
    pend[50] = 1'b1; prio6[50*6 +: 6] = 6'h3f;
    pend[5] = 1'b1; fiq[5] = 1'b1; prio6[5*6 +: 6] = 6'h3f;
    run("R9 max prio");

    // R2: random patterns, narrow priorities to force ties too
    for (int n = 0; n < 400; n++) begin
      pend = {$urandom, $urandom, $urandom};
      mask = {$urandom, $urandom, $urandom} & {$urandom, $urandom, $urandom};
      fiq  = {$urandom, $urandom, $urandom};
      for (int l = 0; l < 96; l++)
        prio6[l*6 +: 6] = (n % 2 == 0) ? 6'($urandom) : 6'($urandom % 4);
      run("R2 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule